// File: doc/BRIEF.md
# Chained Serial Configuration Receiver

This block is the bit-serial loading front end of one device in a chain of devices. All devices share one configuration clock. The block samples `din` on every rising clock edge and looks for a four-bit sync pattern. It then picks up a 24-bit length word that the whole chain shares. After that it takes in a fixed number of its own frames. Each frame it takes is handed out on a parallel write port as a data word, a frame index and a one-cycle write strobe.

The sync pattern and the length word are copied to `dout`, one clock late, so the next device in the chain sees the same header. While the block takes in its own frames, `dout` is held High. Once its own share has been read, every later bit is copied through to `dout`. The downstream devices can then take their frames from that stream.

An internal counter counts configuration clocks from the last initialisation pulse. When the count equals the length word, start-up begins. Every device in the chain reaches this point on the same edge. Two clocks later the user I/O are released, and one clock after that the sequence reports that it has finished.

Top module: `cfgChainRx`

## Requirements
- R1: Before sync, `din` idles at 1. The header begins only after the serial bits 0, 0, 1, 0 have been seen, in that order of arrival. While the block waits for this pattern, and during the length word, `dout` equals the `din` bit sampled on the previous edge.
- R2: The 24 bits that follow the sync pattern are taken MSB first as the chain length word.
- R3: While the block takes in its own frames, `dout` is 1 on every clock.
- R4: Each own frame is one start bit followed by FRAME_BITS data bits, MSB first. On the edge that samples the last data bit, `frameWe` goes High for exactly one cycle. At the same time `frameData` shows the data bits and `frameIdx` shows the frame number, which counts 0, 1, ... in arrival order.
- R5: If an own frame's start bit is 1 rather than 0, `frameErr` goes High after that edge. It stays High until an init pulse or a reset.
- R6: After the last own frame, `dout` equals the `din` bit sampled on the previous edge. This lasts until the next init pulse.
- R7: Edge 0 is the edge that samples `initPulse` High. Take any count L equal to the captured length word. `done` goes High after edge L and stays High.
- R8: `ioEnable` goes High two edges after `done` rises (after edge L+2). `finished` goes High one edge after that (after edge L+3).
- R9: An edge with `initPulse` High, or a Low level on `rstN` at any time, sets the block back to sync search. It sets `dout` to 1 and clears `done`, `ioEnable`, `finished`, `frameWe` and `frameErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| initPulse | input | 1 | Synchronous restart; clears the clock count |
| din | input | 1 | Serial configuration data in |
| dout | output | 1 | Serial data out to the next device |
| frameData | output | FRAME_BITS | Data bits of the frame just completed |
| frameWe | output | 1 | One-cycle write strobe for frameData |
| frameIdx | output | IDX_W | Index of the frame just completed |
| frameErr | output | 1 | Sticky flag for a missing start bit |
| done | output | 1 | Start-up has begun (length matched) |
| ioEnable | output | 1 | User I/O released |
| finished | output | 1 | Start-up sequence complete |

## Verification
The streams vary in three ways. Some start with no idle bits, some with a run of idle ones, and some with a decoy prefix that holds two of the pattern's zeros without matching it. This separates a correct four-bit compare from a shorter or shifted one. Frame data is swept across every 4-bit value, and the number of frames meant for downstream devices runs from zero to three. Because the length word moves with each stream, an off-by-one in the clock count, or a pass-through that starts too early or too late, shows up on `dout` and in the timing of `done`. Streams with a bad start bit exercise the error flag. A stream cut short by an asynchronous reset exercises the return to the idle state.

// File: rtl/cfgChainPkg.sv
package cfgChainPkg;

  typedef enum logic [1:0] {
    ST_SEARCH,
    ST_LENGTH,
    ST_FRAMES,
    ST_PASS
  } rxState_t;

  // strobes from control to datapath, valid for the current edge
  typedef struct packed {
    logic restart;   // init pulse: clear everything
    logic preShift;  // shift din into the sync window
    logic lenShift;  // shift din into the length word
    logic lenCommit; // length word complete after this edge
    logic frmStart;  // din is a frame start bit
    logic frmShift;  // din is a frame data bit
    logic frmWrite;  // din is the last data bit of an own frame
    logic passThru;  // copy din to dout
  } rxCtl_t;

endpackage

// File: rtl/cfgRxControl.sv
module cfgRxControl
  import cfgChainPkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int NUM_FRAMES = 3,
  parameter int LEN_W      = 24,
  parameter int IDX_W      = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initPulse,
  input  logic             preHit,
  output rxCtl_t           ctl,
  output logic [IDX_W-1:0] frameNum
);

  localparam int POS_W = $clog2(FRAME_BITS + 1);
  localparam int LB_W  = $clog2(LEN_W);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BITS);
  localparam logic [LB_W-1:0]  LB_LAST  = LB_W'(LEN_W - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_FRAMES - 1);

  rxState_t         state, stateNext;
  logic [LB_W-1:0]  lenBits, lenBitsNext;
  logic [POS_W-1:0] pos, posNext;
  logic [IDX_W-1:0] idx, idxNext;

  always_comb begin
    ctl         = '0;
    stateNext   = state;
    lenBitsNext = lenBits;
    posNext     = pos;
    idxNext     = idx;
    if (initPulse) begin
      ctl.restart = 1'b1;
      stateNext   = ST_SEARCH;
    end else begin
      unique case (state)
        ST_SEARCH: begin
          ctl.preShift = 1'b1;
          ctl.passThru = 1'b1;
          if (preHit) begin
            stateNext   = ST_LENGTH;
            lenBitsNext = '0;
          end
        end
        ST_LENGTH: begin
          ctl.lenShift = 1'b1;
          ctl.passThru = 1'b1;
          lenBitsNext  = lenBits + 1'b1;
          if (lenBits == LB_LAST) begin
            ctl.lenCommit = 1'b1;
            stateNext     = ST_FRAMES;
            posNext       = '0;
            idxNext       = '0;
          end
        end
        ST_FRAMES: begin
          if (pos == '0) ctl.frmStart = 1'b1;
          else           ctl.frmShift = 1'b1;
          posNext = pos + 1'b1;
          if (pos == POS_LAST) begin
            ctl.frmWrite = 1'b1;
            posNext      = '0;
            idxNext      = idx + 1'b1;
            if (idx == IDX_LAST) stateNext = ST_PASS;
          end
        end
        default: begin
          ctl.passThru = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_SEARCH;
      lenBits <= '0;
      pos     <= '0;
      idx     <= '0;
    end else begin
      state   <= stateNext;
      lenBits <= lenBitsNext;
      pos     <= posNext;
      idx     <= idxNext;
    end
  end

  assign frameNum = idx;

  // R4: frame index never runs past the own frame count while framing
  a_r4_idx_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FRAMES) |-> (idx <= IDX_LAST));

  // R6: pass-through is left only by an init pulse
  a_r6_pass_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PASS && !initPulse) |=> (state == ST_PASS));

endmodule

// File: rtl/cfgRxDatapath.sv
module cfgRxDatapath
  import cfgChainPkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int LEN_W      = 24,
  parameter int IDX_W      = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  din,
  input  rxCtl_t                ctl,
  input  logic [IDX_W-1:0]      frameNum,
  output logic                  preHit,
  output logic                  matchNow,
  output logic                  dout,
  output logic [FRAME_BITS-1:0] frameData,
  output logic                  frameWe,
  output logic [IDX_W-1:0]      frameIdx,
  output logic                  frameErr
);

  localparam int SH_W = FRAME_BITS - 1;
  localparam logic [3:0] SYNC = 4'b0010;

  logic [2:0]      preSh;
  logic [LEN_W-1:0] lenReg, clkCnt;
  logic            lenValid;
  logic [SH_W-1:0] frmSh;
  logic [SH_W:0]   frmShNext;

  assign preHit    = ({preSh, din} == SYNC);
  assign matchNow  = lenValid && ((clkCnt + LEN_W'(1)) == lenReg);
  assign frmShNext = {frmSh, din};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preSh    <= '1;
      lenReg   <= '0;
      lenValid <= 1'b0;
      clkCnt   <= '0;
    end else if (ctl.restart) begin
      preSh    <= '1;
      lenReg   <= '0;
      lenValid <= 1'b0;
      clkCnt   <= '0;
    end else begin
      clkCnt <= clkCnt + LEN_W'(1);
      if (ctl.preShift)  preSh    <= {preSh[1:0], din};
      if (ctl.lenShift)  lenReg   <= {lenReg[LEN_W-2:0], din};
      if (ctl.lenCommit) lenValid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frmSh     <= '0;
      frameData <= '0;
      frameWe   <= 1'b0;
      frameIdx  <= '0;
      frameErr  <= 1'b0;
      dout      <= 1'b1;
    end else if (ctl.restart) begin
      frameWe  <= 1'b0;
      frameErr <= 1'b0;
      dout     <= 1'b1;
    end else begin
      frameWe <= ctl.frmWrite;
      dout    <= ctl.passThru ? din : 1'b1;
      if (ctl.frmShift) frmSh <= frmShNext[SH_W-1:0];
      if (ctl.frmWrite) begin
        frameData <= frmShNext;
        frameIdx  <= frameNum;
      end
      if (ctl.frmStart && din) frameErr <= 1'b1;
    end
  end

  // R4: write strobe lasts one cycle
  a_r4_we_single: assert property (@(posedge clk) disable iff (!rstN)
    frameWe |=> !frameWe);

  // R3: control never asks for pass-through while consuming own frame bits
  a_r3_no_pass_in_frames: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.frmStart || ctl.frmShift) |-> !ctl.passThru);

  // R2: frames are only read after the length word is complete
  a_r2_len_before_frames: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.frmStart || ctl.frmShift) |-> lenValid);

  // R5: error flag is sticky until restart
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !ctl.restart) |=> frameErr);

endmodule

// File: rtl/cfgStartup.sv
module cfgStartup (
  input  logic clk,
  input  logic rstN,
  input  logic restart,
  input  logic matchNow,
  output logic done,
  output logic ioEnable,
  output logic finished
);

  logic stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done     <= 1'b0;
      stage1   <= 1'b0;
      ioEnable <= 1'b0;
      finished <= 1'b0;
    end else if (restart) begin
      done     <= 1'b0;
      stage1   <= 1'b0;
      ioEnable <= 1'b0;
      finished <= 1'b0;
    end else begin
      if (matchNow) done <= 1'b1;
      stage1   <= done;
      ioEnable <= stage1;
      finished <= ioEnable;
    end
  end

  // R7: done holds until a restart
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (done && !restart) |=> done);

  // R8: I/O release follows done by two edges
  a_r8_io_after_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ioEnable) |-> $past(done, 2));

  // R8: finished implies released I/O
  a_r8_fin_after_io: assert property (@(posedge clk) disable iff (!rstN)
    finished |-> ioEnable);

endmodule

// File: rtl/cfgChainRx.sv
module cfgChainRx
  import cfgChainPkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int NUM_FRAMES = 3,
  parameter int LEN_W      = 24,
  localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  initPulse,
  input  logic                  din,
  output logic                  dout,
  output logic [FRAME_BITS-1:0] frameData,
  output logic                  frameWe,
  output logic [IDX_W-1:0]      frameIdx,
  output logic                  frameErr,
  output logic                  done,
  output logic                  ioEnable,
  output logic                  finished
);

  rxCtl_t           ctl;
  logic [IDX_W-1:0] frameNum;
  logic             preHit, matchNow;

  cfgRxControl #(
    .FRAME_BITS(FRAME_BITS), .NUM_FRAMES(NUM_FRAMES),
    .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) i_control (
    .clk(clk), .rstN(rstN), .initPulse(initPulse), .preHit(preHit),
    .ctl(ctl), .frameNum(frameNum)
  );

  cfgRxDatapath #(
    .FRAME_BITS(FRAME_BITS), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .din(din), .ctl(ctl), .frameNum(frameNum),
    .preHit(preHit), .matchNow(matchNow), .dout(dout),
    .frameData(frameData), .frameWe(frameWe), .frameIdx(frameIdx),
    .frameErr(frameErr)
  );

  cfgStartup i_startup (
    .clk(clk), .rstN(rstN), .restart(ctl.restart), .matchNow(matchNow),
    .done(done), .ioEnable(ioEnable), .finished(finished)
  );

endmodule

// File: tb/test_cfgChainRx.sv
module test_cfgChainRx;

  localparam int FB = 4;
  localparam int NF = 2;
  localparam int FL = FB + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initPulse = 1'b0;
  logic din = 1'b1;
  logic dout, frameWe, frameErr, done, ioEnable, finished;
  logic [FB-1:0] frameData;
  logic [0:0] frameIdx;

  int nChecks = 0;
  int nFail = 0;
  logic bits [0:255];
  int expData [0:NF-1];

  always #5 clk = ~clk;

  cfgChainRx #(.FRAME_BITS(FB), .NUM_FRAMES(NF)) i_cfgChainRx (
    .clk(clk), .rstN(rstN), .initPulse(initPulse), .din(din), .dout(dout),
    .frameData(frameData), .frameWe(frameWe), .frameIdx(frameIdx),
    .frameErr(frameErr), .done(done), .ioEnable(ioEnable), .finished(finished)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic b);
    din = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleChecks(input string tag);
    chk({tag, " dout"}, dout, 1);
    chk({tag, " done"}, done, 0);
    chk({tag, " ioEnable"}, ioEnable, 0);
    chk({tag, " finished"}, finished, 0);
    chk({tag, " frameWe"}, frameWe, 0);
    chk({tag, " frameErr"}, frameErr, 0);
  endtask

  // one stream: prefix, sync, length, own frames, downstream frames, idle tail
  task automatic runStream(input int s, input int abortAt);
    int n, pre, lenVal, down, errFrame, pk, ownEnd;
    pk = s % 3;
    down = s % 4;
    errFrame = (s % 7 == 5) ? (s % 2) : -1;
    n = 0;
    if (pk == 1) for (int k = 0; k < 3; k++) begin n++; bits[n] = 1'b1; end
    if (pk == 2) begin
      n++; bits[n] = 1; n++; bits[n] = 0; n++; bits[n] = 0;
      n++; bits[n] = 1; n++; bits[n] = 1;
    end
    n++; bits[n] = 0; n++; bits[n] = 0; n++; bits[n] = 1; n++; bits[n] = 0;
    pre = n;
    ownEnd = pre + 24 + NF * FL;
    lenVal = ownEnd + down * FL;
    for (int k = 23; k >= 0; k--) begin n++; bits[n] = lenVal[k]; end
    for (int j = 0; j < NF; j++) begin
      expData[j] = (s * 3 + j * 7) & 15;
      n++; bits[n] = (j == errFrame);
      for (int k = FB - 1; k >= 0; k--) begin n++; bits[n] = expData[j][k]; end
    end
    for (int j = 0; j < down; j++) begin
      n++; bits[n] = 0;
      for (int k = FB - 1; k >= 0; k--) begin n++; bits[n] = ((s + j) >> k) & 1; end
    end
    for (int k = 0; k < 5; k++) begin n++; bits[n] = 1'b1; end

    initPulse = 1'b1;
    step(1'b1);
    initPulse = 1'b0;
    idleChecks("R9 init");

    for (int i = 1; i <= n; i++) begin
      bit pass, weExp;
      int jw;
      if (i == abortAt) begin
        din = bits[i];
        #2 rstN = 1'b0;
        #1 idleChecks("R9 async reset");
        @(negedge clk);
        idleChecks("R9 held reset");
        rstN = 1'b1;
        return;
      end
      step(bits[i]);
      pass = (i <= pre + 24) || (i > ownEnd);
      if (i <= pre + 24) chk("R1 header echo", dout, pass ? bits[i] : 1);
      else if (i <= ownEnd) chk("R3 own frames high", dout, 1);
      else chk("R6 pass-through", dout, bits[i]);
      weExp = 0; jw = 0;
      for (int j = 0; j < NF; j++)
        if (i == pre + 24 + (j + 1) * FL) begin weExp = 1; jw = j; end
      chk("R4 write strobe", frameWe, weExp);
      if (weExp) begin
        chk("R4 frame data", frameData, expData[jw]);
        chk("R4 frame index", frameIdx, jw);
      end
      chk("R5 start bit error", frameErr,
          (errFrame >= 0 && i >= pre + 25 + errFrame * FL) ? 1 : 0);
      chk("R7 R2 done at length", done, (i >= lenVal) ? 1 : 0);
      chk("R8 io release", ioEnable, (i >= lenVal + 2) ? 1 : 0);
      chk("R8 finished", finished, (i >= lenVal + 3) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    idleChecks("R9 reset");
    rstN = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 16; s++) runStream(s, 0);
    runStream(4, 40);
    idleChecks("R9 after async reset");
    runStream(6, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #1_000_000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule